// File: doc/BRIEF.md
# Fetch Thread Selector

The selector decides which hardware thread may fetch instructions in the current cycle. Each thread supplies a fetch-state code and an active bit. A static policy input picks between a fixed single-thread mode and a round-robin mode. In round-robin mode the selector keeps an ordered priority list of thread IDs. Each grant moves the granted thread to the back of that list.

Up to `N_PICKS` grants are made in one cycle. Each grant slot scans the list as left by the slot before it. The chain stops at the first slot that finds no eligible thread, and it does not start while a drain is pending. The priority list is written once per clock edge, with the result of the last slot. The list is written only when at least one grant was made.

Top module: `fts_sel`

## Requirements
- R1: A thread is eligible only when its active bit is set and its state code is 0 (running), 1 (idle) or 2 (line fill done). Codes 3 (blocked), 4 (squashing), 5 (waiting for a response) and 6 (waiting for a retry) are never granted.
- R2: In round-robin mode (policy 0), each grant slot scans the priority list from the front and grants the first eligible thread. That thread moves to the back of the list. The threads behind it each move forward by one position. A thread that is the only eligible one may be granted again by the next slot.
- R3: When a slot finds no eligible thread, that slot and every later slot report no grant. If slot 0 makes no grant, the priority list keeps its order.
- R4: After reset the priority list is thread 0, 1, 2, ... in ascending order.
- R5: In single-thread mode (policy 1), every enabled slot grants thread 0 whatever its state or active bit. This mode is legal only when N_THREADS is 1. The policy input does not change after reset.
- R6: With N_THREADS equal to 1 in round-robin mode, both slots grant thread 0 when it is active and eligible, and neither slot grants otherwise.
- R7: A slot grants only if the slot before it granted. Slot 0 is the first.
- R8: While drain is high, no slot grants and the priority list keeps its order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | 0 round-robin, 1 single-thread; static after reset |
| active_i | input | N_THREADS | Per-thread active mask |
| state_i | input | 3*N_THREADS | Per-thread fetch-state code, thread i in bits [3i+2:3i] |
| drain_i | input | 1 | Drain pending; suppresses all grants |
| grant_valid_o | output | N_PICKS | Per-slot grant valid |
| grant_tid_o | output | N_PICKS*TID_W | Per-slot granted thread ID, slot k in bits [k*TID_W +: TID_W] |

## Verification
The assertions check on every cycle that the priority list is a permutation of the thread IDs and that a granted thread is active and in a fetchable state. They also check that slot k grants only after slot k-1, that drain and a missing grant leave the list alone, and that the policy input stays fixed. Only the bench scenarios can show the exact rotation order: that the granted thread lands at the back, that a blocked or squashing thread is skipped without losing its place, and that the order after reset is ascending. The bench also covers the two one-thread configurations.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_RUN        = 3'd0,
    ST_IDLE       = 3'd1,
    ST_FILL_DONE  = 3'd2,
    ST_BLOCKED    = 3'd3,
    ST_SQUASH     = 3'd4,
    ST_WAIT_RESP  = 3'd5,
    ST_WAIT_RETRY = 3'd6
  } fetch_state_e;

  typedef enum logic {
    POL_RR     = 1'b0,
    POL_SINGLE = 1'b1
  } fetch_pol_e;

  function automatic logic state_can_fetch(logic [STATE_W-1:0] s);
    return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILL_DONE);
  endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig
  import fts_pkg::*;
#(
  parameter int unsigned N_THREADS = 4
) (
  input  logic [N_THREADS-1:0]         active_i,
  input  logic [N_THREADS*STATE_W-1:0] state_i,
  output logic [N_THREADS-1:0]         elig_o
);

  for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
    assign elig_o[t] = active_i[t] && state_can_fetch(state_i[t*STATE_W +: STATE_W]);
  end

endmodule

// File: rtl/fts_pick.sv
module fts_pick #(
  parameter int unsigned N_THREADS = 4,
  localparam int unsigned TID_W = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int unsigned LIST_W = N_THREADS * TID_W
) (
  input  logic                 en_i,
  input  logic [N_THREADS-1:0] elig_i,
  input  logic [LIST_W-1:0]    list_i,
  output logic                 valid_o,
  output logic [TID_W-1:0]     tid_o,
  output logic [LIST_W-1:0]    list_o
);

  logic             found;
  logic [TID_W-1:0] pos;

  // first eligible entry from the front of the list
  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = 0; i < N_THREADS; i++) begin
      if (!found && elig_i[list_i[i*TID_W +: TID_W]]) begin
        found = 1'b1;
        pos   = TID_W'(i);
      end
    end
  end

  assign valid_o = en_i && found;
  assign tid_o   = list_i[pos*TID_W +: TID_W];

  // granted entry goes to the back, the tail behind it shifts forward
  always_comb begin
    list_o = list_i;
    if (valid_o) begin
      for (int i = 0; i < N_THREADS - 1; i++) begin
        if (TID_W'(i) >= pos) list_o[i*TID_W +: TID_W] = list_i[(i+1)*TID_W +: TID_W];
      end
      list_o[(N_THREADS-1)*TID_W +: TID_W] = tid_o;
    end
  end

endmodule

// File: rtl/fts_sel.sv
module fts_sel
  import fts_pkg::*;
#(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned N_PICKS   = 2,
  localparam int unsigned TID_W  = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
  localparam int unsigned LIST_W = N_THREADS * TID_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         policy_i,
  input  logic [N_THREADS-1:0]         active_i,
  input  logic [N_THREADS*STATE_W-1:0] state_i,
  input  logic                         drain_i,
  output logic [N_PICKS-1:0]           grant_valid_o,
  output logic [N_PICKS*TID_W-1:0]     grant_tid_o
);

  logic [N_THREADS-1:0] elig;
  logic [LIST_W-1:0]    list_q;
  logic [LIST_W-1:0]    list_d;
  logic                 single;

  assign single = (policy_i == POL_SINGLE);

  fts_elig #(.N_THREADS(N_THREADS)) u_elig (
    .active_i (active_i),
    .state_i  (state_i),
    .elig_o   (elig)
  );

  for (genvar k = 0; k < N_PICKS; k++) begin : g_slot
    logic              en_w;
    logic              pv_w;
    logic              gv_w;
    logic [TID_W-1:0]  ptid_w;
    logic [LIST_W-1:0] lin_w;
    logic [LIST_W-1:0] lout_w;

    if (k == 0) begin : g_head
      assign en_w  = !drain_i;
      assign lin_w = list_q;
    end else begin : g_tail
      assign en_w  = g_slot[k-1].gv_w;
      assign lin_w = g_slot[k-1].lout_w;
    end

    fts_pick #(.N_THREADS(N_THREADS)) u_pick (
      .en_i    (en_w),
      .elig_i  (elig),
      .list_i  (lin_w),
      .valid_o (pv_w),
      .tid_o   (ptid_w),
      .list_o  (lout_w)
    );

    assign gv_w = single ? en_w : pv_w;
    assign grant_valid_o[k]               = gv_w;
    assign grant_tid_o[k*TID_W +: TID_W]  = single ? '0 : ptid_w;

    // R1
    grant_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gv_w && !single) |-> (active_i[grant_tid_o[k*TID_W +: TID_W]] &&
        state_i[grant_tid_o[k*TID_W +: TID_W]*STATE_W +: STATE_W] <= ST_FILL_DONE));

    if (k > 0) begin : g_ord
      // R7
      slot_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_valid_o[k] |-> grant_valid_o[k-1]);
    end
  end

  assign list_d = g_slot[N_PICKS-1].lout_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_THREADS; i++) list_q[i*TID_W +: TID_W] <= TID_W'(i);
    end else if (!single) begin
      list_q <= list_d;
    end
  end

  logic [N_THREADS-1:0] occ;
  always_comb begin
    occ = '0;
    for (int i = 0; i < N_THREADS; i++) occ[list_q[i*TID_W +: TID_W]] = 1'b1;
  end

  // R2
  list_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ) == N_THREADS);

  // R3
  no_grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_valid_o[0] |=> $stable(list_q));

  // R8
  drain_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |-> (grant_valid_o == '0));

  // R5
  policy_static_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(policy_i));

  // R5
  single_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single |-> (N_THREADS == 1));

endmodule

// File: tb/fts_sel_tb_top.sv
`timescale 1ns/1ps
module fts_sel_tb_top;

  localparam int NT = 4;
  localparam int NP = 2;

  typedef struct {
    logic [1:0] v;
    int         t0;
    int         t1;
    logic [1:0] sv;
    logic [1:0] rv;
    string      req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [NT-1:0]   act = '0;
  logic [NT*3-1:0] st = '0;
  logic         drn = 1'b0;
  logic [NP-1:0]   gv;
  logic [NP*2-1:0] gt;
  logic [NP-1:0]   s_gv, r_gv;
  logic [NP-1:0]   s_gt, r_gt;

  int errors = 0;
  int checks = 0;
  int mlist[NT];
  exp_t q[$];

  always #4 clk = ~clk;

  fts_sel #(.N_THREADS(NT), .N_PICKS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(1'b0), .active_i(act),
    .state_i(st), .drain_i(drn), .grant_valid_o(gv), .grant_tid_o(gt));

  fts_sel #(.N_THREADS(1), .N_PICKS(NP)) dut_single (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(1'b1), .active_i(act[0]),
    .state_i(st[2:0]), .drain_i(drn), .grant_valid_o(s_gv), .grant_tid_o(s_gt));

  fts_sel #(.N_THREADS(1), .N_PICKS(NP)) dut_one (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(1'b0), .active_i(act[0]),
    .state_i(st[2:0]), .drain_i(drn), .grant_valid_o(r_gv), .grant_tid_o(r_gt));

  function automatic bit can(int i);
    return act[i] && (st[i*3 +: 3] <= 3'd2);
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  // drive one cycle of stimulus and queue the expected grants
  task automatic drive(logic [NT-1:0] a, logic [NT*3-1:0] s, logic d, string req);
    exp_t e;
    bit stop;
    int tids[NP];
    @(posedge clk);
    #1;
    act = a; st = s; drn = d;
    e.v = '0; stop = d;
    for (int k = 0; k < NP; k++) begin
      tids[k] = 0;
      if (!stop) begin
        int p;
        p = -1;
        for (int i = 0; i < NT; i++) if (p < 0 && can(mlist[i])) p = i;
        if (p < 0) stop = 1;
        else begin
          int g;
          g = mlist[p];
          tids[k] = g;
          e.v[k] = 1'b1;
          for (int i = p; i < NT - 1; i++) mlist[i] = mlist[i+1];
          mlist[NT-1] = g;
        end
      end
    end
    e.t0 = tids[0]; e.t1 = tids[1];
    e.sv = d ? 2'b00 : 2'b11;
    e.rv = (!d && can(0)) ? 2'b11 : 2'b00;
    e.req = req;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(gv[0] == e.v[0], e.req, "slot0 valid", int'(gv[0]), int'(e.v[0]));
      check(gv[1] == e.v[1], e.req, "slot1 valid", int'(gv[1]), int'(e.v[1]));
      if (e.v[0]) check(int'(gt[1:0]) == e.t0, e.req, "slot0 tid", int'(gt[1:0]), e.t0);
      if (e.v[1]) check(int'(gt[3:2]) == e.t1, e.req, "slot1 tid", int'(gt[3:2]), e.t1);
      check(s_gv == e.sv && s_gt == '0, "R5", "single-thread grants",
            int'({s_gv, s_gt}), int'({e.sv, 2'b00}));
      check(r_gv == e.rv && r_gt == '0, "R6", "one-thread round-robin",
            int'({r_gv, r_gt}), int'({e.rv, 2'b00}));
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) mlist[i] = i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R4: ascending order after reset, all running
    drive(4'hF, 12'h000, 1'b0, "R4");
    drive(4'hF, 12'h000, 1'b0, "R2");
    // R1: thread0 blocked, 1 waiting response, 2 idle, 3 fill done
    drive(4'hF, {3'd2, 3'd1, 3'd5, 3'd3}, 1'b0, "R1");
    // R2: only thread 1 eligible, granted twice
    drive(4'hF, {3'd3, 3'd6, 3'd0, 3'd4}, 1'b0, "R2");
    // R3: nothing eligible
    drive(4'hF, {3'd5, 3'd6, 3'd4, 3'd3}, 1'b0, "R3");
    drive(4'hF, 12'h000, 1'b0, "R3");
    // R8: drain suppresses grants and holds order
    drive(4'hF, 12'h000, 1'b1, "R8");
    drive(4'hF, 12'h000, 1'b0, "R8");
    // R1: inactive threads skipped
    drive(4'b0101, 12'h000, 1'b0, "R1");
    // R7: one eligible thread after a gap
    drive(4'b1000, 12'h000, 1'b0, "R7");
    drive(4'b0001, {3'd0, 3'd0, 3'd0, 3'd3}, 1'b0, "R7");
    drive(4'b0001, 12'h000, 1'b0, "R6");
    for (int n = 0; n < 60; n++) begin
      logic [NT*3-1:0] s;
      for (int i = 0; i < NT; i++) s[i*3 +: 3] = 3'($urandom_range(0, 6));
      drive(4'($urandom), s, ($urandom_range(0, 7) == 0), "R2");
    end
    @(posedge clk);
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule